// File: doc/BRIEF.md
# Inter-processor mailbox controller

This block lets up to four processors exchange 64-bit messages over eight channels. Each channel owns one 64-bit message slot in a shared store, and there is one shared pending bit per channel. Each processor has an enable byte that masks which pending channels may interrupt it, a write-one-to-clear byte that drops pending bits, a read-only status byte, a scratch byte with no side effects, and one interrupt line of its own.

To send, a processor writes the message into the channel's slot and clears any stale pending bit for that channel through the target's clear byte. It then sets the channel bit in the target's enable byte and writes the channel bit to the shared set register. The target sees its interrupt line rise. It reads its status byte, fetches the slot, clears the pending bit and drops its own enable bit. That enable bit is the completion flag: the sender polls it until it reads 0.

The register bus is byte addressed and accepts one access per cycle. It has no back-pressure: a read or write strobe is always taken in the cycle it is high. Register writes use `bus_wdata[7:0]`. Writes into the slot region use all 64 bits, and address bits [2:0] are ignored there. Each read returns data exactly one cycle later, flagged by `bus_rvalid`, and the consumer must take it in that cycle.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset all enable, scratch and pending bits, all slots, `irq` and `bus_rvalid` are 0, and every read returns 0.
- R2: A write at byte offset 0x400 + 8*n stores all 64 bits of `bus_wdata` into slot n (n = 0..7). A read at the same offset returns the slot.
- R3: A write at offset 0x60 sets the pending bit of every channel whose data bit is 1. Bits written as 0 change nothing. A read at 0x60 returns the pending bits in [7:0].
- R4: A write at offset 0x10 + 16*c clears the pending bit of every channel whose data bit is 1. Bits written as 0 change nothing. A read at that offset returns the pending bits. If a set and a clear of the same bit fall in one cycle, the clear wins.
- R5: The enable byte of processor c sits at offset 4*c, with bit n standing for channel n. It is read/write.
- R6: The status byte of processor c sits at offset 0x18 + 16*c. It reads as pending AND enable of c, and writes to it are ignored.
- R7: `irq[c]` is the OR of the status bits of processor c. It reflects a register write in the cycle right after the write strobe.
- R8: The scratch byte at offset 4*c + 2 is a plain read/write register. Writing it changes neither `irq` nor the pending bits.
- R9: A read at any unmapped offset returns 0, and a write there changes no state.
- R10: `bus_rvalid` is high exactly in the cycle after a cycle with `bus_rd` high, and `bus_rdata` holds the addressed value in that cycle.
- R11: In a full send and acknowledge exchange, the target's interrupt rises when the set register is written. After the target has cleared the pending bit and its own enable bit, the sender's poll of that enable bit reads 0 and the interrupt is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe, taken in the cycle it is high |
| bus_rd | input | 1 | Read strobe, taken in the cycle it is high |
| bus_addr | input | 11 | Byte address |
| bus_wdata | input | 64 | Write data; [7:0] for registers, all bits for slots |
| bus_rdata | output | 64 | Read data, valid while bus_rvalid is high |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| irq | output | 4 | Interrupt line per processor |

## Verification
All register state updates on the clock edge that takes a write. So `irq` is due, and is checked, on the falling edge right after that edge, with no extra wait. Read results are due one cycle after the read strobe. The driver queues the expected value when it raises `bus_rd`, and a monitor pops the queue on each falling edge where `bus_rvalid` is high. A result that comes early, late or without a request is therefore caught as a mismatch or as a leftover queue entry. The checks walk every register kind for several processors, the ignored writes, the unmapped holes, and one complete send and acknowledge exchange.

// File: rtl/ipc_mbox_pkg.sv
package ipc_mbox_pkg;
  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_EN,
    TGT_SCR,
    TGT_CLR,
    TGT_STAT,
    TGT_SET,
    TGT_SLOT
  } tgt_e;

  localparam int OFF_CLR_BASE  = 'h10;
  localparam int OFF_STAT_LANE = 'h8;
  localparam int OFF_SET       = 'h60;
  localparam int OFF_CTX       = 'h400;
endpackage

// File: rtl/ipc_mbox_decode.sv
module ipc_mbox_decode
  import ipc_mbox_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int NUM_CPU  = 4,
  parameter int NUM_CHAN = 8,
  localparam int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int CHAN_W  = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output tgt_e              tgt,
  output logic [CPU_W-1:0]  cpu,
  output logic [CHAN_W-1:0] chan
);
  localparam int CTX_END = OFF_CTX + NUM_CHAN * 8;
  localparam int CPU_END = OFF_CLR_BASE + NUM_CPU * 16;

  int a;

  always_comb begin
    a    = int'(addr);
    tgt  = TGT_NONE;
    cpu  = '0;
    chan = '0;
    if (a >= OFF_CTX && a < CTX_END) begin
      tgt  = TGT_SLOT;
      chan = CHAN_W'((a - OFF_CTX) >> 3);
    end else if (a == OFF_SET) begin
      tgt = TGT_SET;
    end else if (a < NUM_CPU * 4) begin
      cpu = CPU_W'(a >> 2);
      if (a[1:0] == 2'd0)      tgt = TGT_EN;
      else if (a[1:0] == 2'd2) tgt = TGT_SCR;
    end else if (a >= OFF_CLR_BASE && a < CPU_END) begin
      cpu = CPU_W'((a - OFF_CLR_BASE) >> 4);
      if (a[3:0] == 4'd0)                 tgt = TGT_CLR;
      else if (a[3:0] == OFF_STAT_LANE)   tgt = TGT_STAT;
    end
  end
endmodule

// File: rtl/ipc_mbox_pending.sv
module ipc_mbox_pending #(
  parameter int NUM_CHAN = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_CHAN-1:0] set_mask,
  input  logic [NUM_CHAN-1:0] clr_mask,
  output logic [NUM_CHAN-1:0] pend
);
  // clear takes priority over set on the same bit
  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= (pend | set_mask) & ~clr_mask;
  end
endmodule

// File: rtl/ipc_mbox_cpu_port.sv
module ipc_mbox_cpu_port #(
  parameter int NUM_CHAN = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en_we,
  input  logic                scr_we,
  input  logic [7:0]          wbyte,
  input  logic [NUM_CHAN-1:0] pend,
  output logic [NUM_CHAN-1:0] en,
  output logic [7:0]          scr,
  output logic [NUM_CHAN-1:0] stat,
  output logic                irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en  <= '0;
      scr <= '0;
    end else begin
      if (en_we)  en  <= wbyte[NUM_CHAN-1:0];
      if (scr_we) scr <= wbyte;
    end
  end

  assign stat = pend & en;
  assign irq  = |stat;
endmodule

// File: rtl/ipc_mbox_slots.sv
module ipc_mbox_slots #(
  parameter int NUM_CHAN = 8,
  parameter int DATA_W   = 64,
  localparam int CHAN_W  = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [CHAN_W-1:0] widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CHAN_W-1:0] ridx,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [NUM_CHAN];

  for (genvar n = 0; n < NUM_CHAN; n++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)                              mem[n] <= '0;
      else if (we && widx == CHAN_W'(n))    mem[n] <= wdata;
    end
  end

  assign rdata = mem[ridx];
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import ipc_mbox_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int NUM_CPU  = 4,
  parameter int NUM_CHAN = 8,
  parameter int DATA_W   = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               bus_rvalid,
  output logic [NUM_CPU-1:0] irq
);
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;
  localparam int CHAN_W = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1;

  tgt_e              tgt;
  logic [CPU_W-1:0]  cpu;
  logic [CHAN_W-1:0] chan;

  ipc_mbox_decode #(.ADDR_W(ADDR_W), .NUM_CPU(NUM_CPU), .NUM_CHAN(NUM_CHAN)) u_dec (
    .addr(bus_addr), .tgt(tgt), .cpu(cpu), .chan(chan)
  );

  logic [NUM_CHAN-1:0] pend, set_mask, clr_mask;
  assign set_mask = (bus_wr && tgt == TGT_SET) ? bus_wdata[NUM_CHAN-1:0] : '0;
  assign clr_mask = (bus_wr && tgt == TGT_CLR) ? bus_wdata[NUM_CHAN-1:0] : '0;

  ipc_mbox_pending #(.NUM_CHAN(NUM_CHAN)) u_pend (
    .clk(clk), .rst(rst), .set_mask(set_mask), .clr_mask(clr_mask), .pend(pend)
  );

  logic [NUM_CHAN-1:0] en_a   [NUM_CPU];
  logic [NUM_CHAN-1:0] stat_a [NUM_CPU];
  logic [7:0]          scr_a  [NUM_CPU];

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    ipc_mbox_cpu_port #(.NUM_CHAN(NUM_CHAN)) u_port (
      .clk   (clk),
      .rst   (rst),
      .en_we (bus_wr && tgt == TGT_EN  && cpu == CPU_W'(c)),
      .scr_we(bus_wr && tgt == TGT_SCR && cpu == CPU_W'(c)),
      .wbyte (bus_wdata[7:0]),
      .pend  (pend),
      .en    (en_a[c]),
      .scr   (scr_a[c]),
      .stat  (stat_a[c]),
      .irq   (irq[c])
    );
  end

  logic [DATA_W-1:0] slot_q;
  ipc_mbox_slots #(.NUM_CHAN(NUM_CHAN), .DATA_W(DATA_W)) u_slots (
    .clk(clk), .rst(rst),
    .we(bus_wr && tgt == TGT_SLOT), .widx(chan), .wdata(bus_wdata),
    .ridx(chan), .rdata(slot_q)
  );

  logic [DATA_W-1:0] rd_d;
  always_comb begin
    unique case (tgt)
      TGT_EN:           rd_d = DATA_W'(en_a[cpu]);
      TGT_SCR:          rd_d = DATA_W'(scr_a[cpu]);
      TGT_STAT:         rd_d = DATA_W'(stat_a[cpu]);
      TGT_CLR, TGT_SET: rd_d = DATA_W'(pend);
      TGT_SLOT:         rd_d = slot_q;
      default:          rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_rd;
      bus_rdata  <= bus_rd ? rd_d : '0;
    end
  end
endmodule

// File: rtl/ipc_mailbox_chk.sv
module ipc_mailbox_chk #(
  parameter int ADDR_W   = 11,
  parameter int NUM_CPU  = 4,
  parameter int NUM_CHAN = 8,
  parameter int DATA_W   = 64
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_wr,
  input logic               bus_rd,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DATA_W-1:0]  bus_rdata,
  input logic               bus_rvalid,
  input logic [NUM_CPU-1:0] irq
);
  localparam int CTX_END = 'h400 + NUM_CHAN * 8;

  assert_rvalid_follows_R10: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);
  assert_no_spurious_rvalid_R10: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> !bus_rvalid);
  assert_irq_moves_on_write_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(irq) |-> $past(bus_wr));
  assert_hole_reads_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_rvalid && int'($past(bus_addr)) >= CTX_END) |-> bus_rdata == '0);
  assert_reset_clean_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (irq == '0 && !bus_rvalid));
endmodule

bind ipc_mailbox ipc_mailbox_chk #(
  .ADDR_W(ADDR_W), .NUM_CPU(NUM_CPU), .NUM_CHAN(NUM_CHAN), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/ipc_mailbox_tb_top.sv
module ipc_mailbox_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [10:0] bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic [63:0] bus_rdata;
  logic        bus_rvalid;
  logic [3:0]  irq;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [63:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  ipc_mailbox dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .irq(irq)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [10:0] a, logic [63:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // driver: queue the expectation as the read is issued
  task automatic rd(logic [10:0] a, logic [63:0] exp, string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // monitor: one result due per read, one cycle after the strobe
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        check("R10 unrequested read data", 64'd1, 64'd0);
      end else begin
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 irq after reset", 64'(irq), 64'd0);
    check("R1 rvalid after reset", 64'(bus_rvalid), 64'd0);
    rd(11'h000, 64'd0, "R1 enable0 reset");
    rd(11'h400, 64'd0, "R1 slot0 reset");
    rd(11'h060, 64'd0, "R1 pending reset");

    wr(11'h400, 64'hDEAD_BEEF_1234_5678);
    wr(11'h438, 64'hA5A5_0000_FFFF_5A5A);
    rd(11'h400, 64'hDEAD_BEEF_1234_5678, "R2 slot0");
    rd(11'h43F, 64'hA5A5_0000_FFFF_5A5A, "R2 slot7");

    wr(11'h004, 64'h05);
    rd(11'h004, 64'h05, "R5 enable1");
    rd(11'h00C, 64'h00, "R5 enable3 untouched");
    wr(11'h00A, 64'hA5);
    check("R8 scratch no irq", 64'(irq), 64'd0);
    rd(11'h00A, 64'hA5, "R8 scratch2");
    rd(11'h060, 64'h00, "R8 scratch no pending");

    wr(11'h060, 64'h01);
    check("R7 irq1 raised", 64'(irq), 64'b0010);
    rd(11'h028, 64'h01, "R6 status1");
    rd(11'h018, 64'h00, "R6 status0 masked");
    wr(11'h060, 64'h00);
    rd(11'h060, 64'h01, "R3 zero write keeps pending");
    wr(11'h060, 64'h80);
    rd(11'h060, 64'h81, "R3 second set");
    wr(11'h028, 64'hFF);
    rd(11'h028, 64'h01, "R6 status write ignored");
    wr(11'h010, 64'h00);
    rd(11'h010, 64'h81, "R4 zero clear no effect");
    wr(11'h020, 64'h01);
    check("R7 irq1 dropped", 64'(irq), 64'd0);
    rd(11'h020, 64'h80, "R4 w1c bit0");
    wr(11'h040, 64'h80);
    rd(11'h060, 64'h00, "R4 w1c via cpu3");

    wr(11'h100, 64'hFF);
    wr(11'h050, 64'hFF);
    check("R9 hole write no irq", 64'(irq), 64'd0);
    rd(11'h100, 64'd0, "R9 hole 0x100");
    rd(11'h440, 64'd0, "R9 past slots");
    rd(11'h050, 64'd0, "R9 fifth cpu clear");
    rd(11'h060, 64'd0, "R9 hole write no pending");

    wr(11'h418, 64'h0123_4567_89AB_CDEF);
    wr(11'h030, 64'h08);
    rd(11'h008, 64'h00, "R11 target enable idle");
    wr(11'h008, 64'h08);
    wr(11'h060, 64'h08);
    check("R11 target irq raised", 64'(irq), 64'b0100);
    rd(11'h038, 64'h08, "R11 target status");
    rd(11'h418, 64'h0123_4567_89AB_CDEF, "R11 message");
    wr(11'h030, 64'h08);
    wr(11'h008, 64'h00);
    rd(11'h008, 64'h00, "R11 sender poll done");
    check("R11 irq low after ack", 64'(irq), 64'd0);
    rd(11'h00A, 64'hA5, "R8 scratch kept");

    repeat (3) @(negedge clk);
    check("R10 all reads answered", 64'(exp_q.size()), 64'd0);
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule